// File: doc/BRIEF.md
# Interlaced Fetch/Data Memory Arbiter

This block lets a processor core with separate instruction-fetch, data-read and data-write ports run from a single single-ported, single-data-rate 32-bit memory. Instructions are 16 bits wide and two of them share one memory word. The arbiter keeps the last fetched word. When a fetch asks for the same word again, it answers from that copy without touching the memory. This leaves the memory free in roughly every other cycle of straight-line code, and data accesses use those free cycles.

When more than one request wants the memory in the same cycle, a fixed priority picks one. Only the ports that lose see their ready signal low. A port holds its request until it sees ready. The block also decodes the system address map. Data addresses at or above a peripheral base go to a separate peripheral bus, so peripheral traffic does not compete with memory traffic. The memory array and the peripherals are outside the block.

Top module: `mem_interlace_arb`

## Requirements
- R1: A data write to the memory region (byte address below `(IMEM_WORDS+DMEM_WORDS)*4`) drives `mem_en=1`, `mem_we=1`, `mem_addr = dw_addr>>2` and `mem_wdata = dw_wdata` in the same cycle, with `dw_ready=1` in that cycle. A data write is never stalled.
- R2: A granted data read to the memory region drives `mem_en=1`, `mem_we=0` and `mem_addr = dr_addr>>2` in its issue cycle, with `dr_ready=0`. In the next cycle `dr_ready=1` and `dr_rdata` is the memory word. The port is not arbitrated again in that response cycle.
- R3: A fetch whose word address (`if_addr>>2`) differs from the kept word is a miss. In the cycle it is granted it accesses memory at `if_addr>>2` with `if_ready=0`. In the next cycle `if_ready=1` and `if_rdata` is the memory word.
- R4: A fetch whose word address equals the kept word is a hit. It gets `if_ready=1` in the same cycle, and `if_rdata` is the kept word. The fetch makes no memory access.
- R5: After reset the kept word is invalid, so the first fetch always goes to memory, even if its address matches the word kept before reset. Right after reset, with no requests, all ready outputs, `mem_en` and `per_en` are 0.
- R6: Memory priority within a cycle is data write, then data read, then fetch. A losing port has ready=0 and is served in a later cycle while it keeps its request.
- R7: A data access that arrives while the fetch side does not need memory (in a hit or response cycle) is granted in that cycle with no stall.
- R8: A data access at or above `PER_BASE` (0x000F0000) goes to the peripheral port and not to memory. It drives `per_en=1`, `per_we` for a write, and `per_addr` as the full byte address. Read data comes from `per_rdata` in the next cycle. A peripheral access and a memory access may be granted in the same cycle.
- R9: A data address in neither region is unmapped. A write there gets `dw_ready=1` and changes nothing. A read there gets `dr_ready=1` in the next cycle with `dr_rdata=0`.
- R10: A fetch that moves to a different word (a branch) forces a memory fetch, even one cycle after the previous fetch response.
- R11: The instruction region starts at byte 0 and the data region follows it. Both lie in the one memory, and the data ports can reach either region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_en | input | 1 | Fetch request |
| if_addr | input | AW | Fetch byte address |
| if_ready | output | 1 | Fetch data valid |
| if_rdata | output | DW | Fetched word |
| dr_en | input | 1 | Data read request |
| dr_addr | input | AW | Data read byte address |
| dr_ready | output | 1 | Read response valid |
| dr_rdata | output | DW | Read data |
| dw_en | input | 1 | Data write request |
| dw_addr | input | AW | Data write byte address |
| dw_wdata | input | DW | Write data |
| dw_ready | output | 1 | Write accepted |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | MA | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after access |
| per_en | output | 1 | Peripheral access strobe |
| per_we | output | 1 | Peripheral write |
| per_addr | output | AW | Peripheral byte address |
| per_wdata | output | DW | Peripheral write data |
| per_rdata | input | DW | Peripheral read data, one cycle after access |

## Verification
The bench builds the block with 16 instruction words and 16 data words. This puts the memory region at bytes 0 to 127 and leaves a 5-bit word address, so unmapped addresses just above the memory are easy to reach. The unmapped write at 0x200 would land on word 0 if the address were only truncated, and the bench checks that word 0 is unchanged afterwards. The peripheral base keeps its default, so peripheral writes and memory reads can be granted in the same cycle as separate bus operations. Three-way collisions, read retries after a lost cycle, branch refetches one cycle after a response, and the invalid kept word after a second reset are all exercised with this small map.

// File: rtl/mab_pkg.sv
package mab_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Target of a data address after map decoding.
  typedef enum logic [1:0] {
    RG_MEM  = 2'd0,
    RG_PER  = 2'd1,
    RG_NONE = 2'd2
  } region_e;

  // Peripheral space wins, then the shared memory, everything else is unmapped.
  function automatic region_e classify(input logic [63:0] a,
                                       input logic [63:0] mem_bytes,
                                       input logic [63:0] per_base);
    if (a >= per_base)       return RG_PER;
    else if (a < mem_bytes)  return RG_MEM;
    else                     return RG_NONE;
  endfunction

  // Memory word index of a byte address.
  function automatic logic [63:0] word_index(input logic [63:0] a, input int shift);
    return a >> shift;
  endfunction
endpackage

// File: rtl/mab_region_dec.sv
module mab_region_dec
  import mab_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          MA        = 7,
  parameter int          WSH       = 2,
  parameter logic [63:0] MEM_BYTES = 64'd512,
  parameter logic [63:0] PER_BASE  = 64'h000F_0000
) (
  input  logic [AW-1:0] addr,
  output region_e       region,
  output logic [MA-1:0] word
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [63:0] addr_w;
  logic [63:0] widx;

  assign addr_w = 64'(addr);
  assign widx   = word_index(addr_w, WSH);
  assign region = classify(addr_w, MEM_BYTES, PER_BASE);
  assign word   = widx[MA-1:0];
endmodule

// File: rtl/mab_fetch_track.sv
module mab_fetch_track #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int WSH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] addr,
  input  logic          grant,
  input  logic [DW-1:0] mem_rdata,
  output logic          need,
  output logic          hit,
  output logic          pend,
  output logic          ready,
  output logic [DW-1:0] rdata
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int TW = AW - WSH;

  logic [TW-1:0] cur_word;
  logic [TW-1:0] kept_word;
  logic          kept_vld;
  logic [DW-1:0] kept_data;

  assign cur_word = addr[AW-1:WSH];

  // Same word as the one already held: no memory cycle needed.
  assign hit   = req && !pend && kept_vld && (cur_word == kept_word);
  assign need  = req && !pend && !hit;
  assign ready = pend || hit;
  assign rdata = pend ? mem_rdata : kept_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      kept_vld  <= 1'b0;
      kept_word <= '0;
      kept_data <= '0;
    end else begin
      pend <= grant;
      if (grant) begin
        kept_word <= cur_word;
        kept_vld  <= 1'b1;
      end
      if (pend) kept_data <= mem_rdata;
    end
  end

  // R4
  fetch_grant_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> need);

  // R3
  fetch_resp_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> ready);
endmodule

// File: rtl/mab_grant.sv
module mab_grant
  import mab_pkg::*;
(
  input  logic    wr_req,
  input  region_e wr_rg,
  input  logic    rd_ask,
  input  region_e rd_rg,
  input  logic    f_need,
  output logic    wr_mem,
  output logic    wr_per,
  output logic    rd_gnt,
  output logic    rd_mem,
  output logic    rd_per,
  output logic    f_gnt
);
  timeunit 1ns;
  timeprecision 1ps;

  logic rd_blocked;

  // Writes always win their target bus.
  assign wr_mem = wr_req && (wr_rg == RG_MEM);
  assign wr_per = wr_req && (wr_rg == RG_PER);

  // A read only loses when the write claims the same bus.
  assign rd_blocked = ((rd_rg == RG_MEM) && wr_mem) || ((rd_rg == RG_PER) && wr_per);
  assign rd_gnt     = rd_ask && !rd_blocked;
  assign rd_mem     = rd_gnt && (rd_rg == RG_MEM);
  assign rd_per     = rd_gnt && (rd_rg == RG_PER);

  // Fetch takes whatever memory slot is left.
  assign f_gnt = f_need && !wr_mem && !rd_mem;
endmodule

// File: rtl/mem_interlace_arb.sv
module mem_interlace_arb
  import mab_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          DW         = 32,
  parameter int          IMEM_WORDS = 64,
  parameter int          DMEM_WORDS = 64,
  parameter logic [63:0] PER_BASE   = 64'h000F_0000,
  localparam int         MEM_WORDS  = IMEM_WORDS + DMEM_WORDS,
  localparam int         MA         = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          if_en,
  input  logic [AW-1:0] if_addr,
  output logic          if_ready,
  output logic [DW-1:0] if_rdata,
  input  logic          dr_en,
  input  logic [AW-1:0] dr_addr,
  output logic          dr_ready,
  output logic [DW-1:0] dr_rdata,
  input  logic          dw_en,
  input  logic [AW-1:0] dw_addr,
  input  logic [DW-1:0] dw_wdata,
  output logic          dw_ready,
  output logic          mem_en,
  output logic          mem_we,
  output logic [MA-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          per_en,
  output logic          per_we,
  output logic [AW-1:0] per_addr,
  output logic [DW-1:0] per_wdata,
  input  logic [DW-1:0] per_rdata
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int          WSH       = $clog2(DW / 8);
  localparam logic [63:0] MEM_BYTES = 64'(MEM_WORDS) * 64'(DW / 8);
  localparam int          NDP       = 2;  // data ports: 0 = write, 1 = read

  // Map decoding for both data ports.
  logic [AW-1:0] dp_addr [NDP];
  region_e       dp_rg   [NDP];
  logic [MA-1:0] dp_word [NDP];

  assign dp_addr[0] = dw_addr;
  assign dp_addr[1] = dr_addr;

  for (genvar p = 0; p < NDP; p++) begin : g_dec
    mab_region_dec #(
      .AW(AW), .MA(MA), .WSH(WSH), .MEM_BYTES(MEM_BYTES), .PER_BASE(PER_BASE)
    ) u_dec (
      .addr   (dp_addr[p]),
      .region (dp_rg[p]),
      .word   (dp_word[p])
    );
  end

  // Named internal events.
  logic    f_need, f_hit, f_pend, f_gnt;
  logic    wr_mem, wr_per, rd_gnt, rd_mem, rd_per, rd_ask;
  logic    rd_pend;
  region_e rd_sel_q;
  logic [MA-1:0] f_word;

  assign rd_ask = dr_en && !rd_pend;
  assign f_word = if_addr[WSH +: MA];

  mab_fetch_track #(.AW(AW), .DW(DW), .WSH(WSH)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (if_en),
    .addr      (if_addr),
    .grant     (f_gnt),
    .mem_rdata (mem_rdata),
    .need      (f_need),
    .hit       (f_hit),
    .pend      (f_pend),
    .ready     (if_ready),
    .rdata     (if_rdata)
  );

  mab_grant u_grant (
    .wr_req (dw_en),
    .wr_rg  (dp_rg[0]),
    .rd_ask (rd_ask),
    .rd_rg  (dp_rg[1]),
    .f_need (f_need),
    .wr_mem (wr_mem),
    .wr_per (wr_per),
    .rd_gnt (rd_gnt),
    .rd_mem (rd_mem),
    .rd_per (rd_per),
    .f_gnt  (f_gnt)
  );

  // Memory bus: one owner per cycle.
  always_comb begin
    mem_en   = wr_mem || rd_mem || f_gnt;
    mem_we   = wr_mem;
    mem_addr = '0;
    if (wr_mem)      mem_addr = dp_word[0];
    else if (rd_mem) mem_addr = dp_word[1];
    else if (f_gnt)  mem_addr = f_word;
  end
  assign mem_wdata = dw_wdata;

  // Peripheral bus.
  always_comb begin
    per_en   = wr_per || rd_per;
    per_we   = wr_per;
    per_addr = '0;
    if (wr_per)      per_addr = dw_addr;
    else if (rd_per) per_addr = dr_addr;
  end
  assign per_wdata = dw_wdata;

  // Writes complete in the cycle they are seen.
  assign dw_ready = dw_en;

  // Read response tracking.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend  <= 1'b0;
      rd_sel_q <= RG_NONE;
    end else begin
      rd_pend <= rd_gnt;
      if (rd_gnt) rd_sel_q <= dp_rg[1];
    end
  end

  assign dr_ready = rd_pend;
  always_comb begin
    dr_rdata = '0;
    if (rd_pend) begin
      case (rd_sel_q)
        RG_MEM:  dr_rdata = mem_rdata;
        RG_PER:  dr_rdata = per_rdata;
        default: dr_rdata = '0;
      endcase
    end
  end

  // R6
  mem_single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_mem, rd_mem, f_gnt}));

  // R6
  mem_resp_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_pend && rd_pend && (rd_sel_q == RG_MEM)));

  // R2
  rd_resp_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_gnt |=> dr_ready);

  // R6
  rd_lose_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ask && (dp_rg[1] == RG_MEM) && dw_en && (dp_rg[0] == RG_MEM)) |=> !dr_ready);

  // R8
  per_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_en |-> (64'(per_addr) >= PER_BASE));

  // R9
  wr_unmapped_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_en && (dp_rg[0] == RG_NONE)) |-> (!mem_we && !per_we));

  // R4
  fetch_no_refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_pend && if_en) |=> !(if_en && $stable(if_addr[AW-1:WSH]) && f_gnt));

  // R7
  data_free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_hit && rd_ask && (dp_rg[1] == RG_MEM) && !dw_en) |-> rd_mem);
endmodule

// File: tb/tb_mem_interlace_arb.sv
module tb_mem_interlace_arb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int MA = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          if_en = 1'b0, dr_en = 1'b0, dw_en = 1'b0;
  logic [AW-1:0] if_addr = '0, dr_addr = '0, dw_addr = '0;
  logic [DW-1:0] dw_wdata;
  logic          if_ready, dr_ready, dw_ready;
  logic [DW-1:0] if_rdata, dr_rdata;
  logic          mem_en, mem_we, per_en, per_we;
  logic [MA-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, per_wdata;
  logic [DW-1:0] mem_rdata = '0, per_rdata = '0;
  logic [AW-1:0] per_addr;

  int ntests = 0;
  int nfail  = 0;

  assign dw_wdata = 32'hD000_0000 | dw_addr;

  always #2 clk = ~clk;

  mem_interlace_arb #(.AW(AW), .DW(DW), .IMEM_WORDS(16), .DMEM_WORDS(16)) dut (
    .clk(clk), .rst_n(rst_n),
    .if_en(if_en), .if_addr(if_addr), .if_ready(if_ready), .if_rdata(if_rdata),
    .dr_en(dr_en), .dr_addr(dr_addr), .dr_ready(dr_ready), .dr_rdata(dr_rdata),
    .dw_en(dw_en), .dw_addr(dw_addr), .dw_wdata(dw_wdata), .dw_ready(dw_ready),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .per_en(per_en), .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata),
    .per_rdata(per_rdata)
  );

  // Fixture: synchronous memory and a peripheral that echoes its address.
  logic [DW-1:0] marr [32];
  logic [AW-1:0] pw_addr = '0;
  logic [DW-1:0] pw_data = '0;

  initial for (int i = 0; i < 32; i++) marr[i] = 32'hA000_0000 + i;

  always @(posedge clk) begin
    if (mem_en && mem_we) marr[mem_addr] <= mem_wdata;
    else if (mem_en)      mem_rdata <= marr[mem_addr];
    if (per_en && per_we) begin
      pw_addr <= per_addr;
      pw_data <= per_wdata;
    end else if (per_en) per_rdata <= {16'hBEEF, per_addr[15:0]};
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic ie, input logic [19:0] ia, input logic re, input logic [19:0] ra,
                     input logic we, input logic [19:0] wa);
    @(negedge clk);
    if_en = ie; if_addr = 32'(ia);
    dr_en = re; dr_addr = 32'(ra);
    dw_en = we; dw_addr = 32'(wa);
    #1;
  endtask

  typedef struct packed {
    logic        ie; logic [19:0] ia;
    logic        re; logic [19:0] ra;
    logic        we; logic [19:0] wa;
    logic        m_en; logic m_we; logic [4:0] m_a;
    logic        i_r; logic d_r; logic w_r; logic p_en;
  } vec_t;

  localparam vec_t TAB [21] = '{
    '{1'b1,20'h00000, 1'b0,20'h00000, 1'b0,20'h00000, 1'b1,1'b0,5'd0,  1'b0,1'b0,1'b0,1'b0},
    '{1'b1,20'h00000, 1'b0,20'h00000, 1'b0,20'h00000, 1'b0,1'b0,5'd0,  1'b1,1'b0,1'b0,1'b0},
    '{1'b1,20'h00002, 1'b1,20'h00040, 1'b0,20'h00000, 1'b1,1'b0,5'd16, 1'b1,1'b0,1'b0,1'b0},
    '{1'b1,20'h00004, 1'b1,20'h00040, 1'b0,20'h00000, 1'b1,1'b0,5'd1,  1'b0,1'b1,1'b0,1'b0},
    '{1'b1,20'h00004, 1'b0,20'h00000, 1'b1,20'h00044, 1'b1,1'b1,5'd17, 1'b1,1'b0,1'b1,1'b0},
    '{1'b1,20'h00006, 1'b1,20'h0004C, 1'b1,20'h00048, 1'b1,1'b1,5'd18, 1'b1,1'b0,1'b1,1'b0},
    '{1'b1,20'h00008, 1'b1,20'h0004C, 1'b0,20'h00000, 1'b1,1'b0,5'd19, 1'b0,1'b0,1'b0,1'b0},
    '{1'b1,20'h00008, 1'b1,20'h0004C, 1'b0,20'h00000, 1'b1,1'b0,5'd2,  1'b0,1'b1,1'b0,1'b0},
    '{1'b1,20'h00008, 1'b0,20'h00000, 1'b0,20'h00000, 1'b0,1'b0,5'd0,  1'b1,1'b0,1'b0,1'b0},
    '{1'b1,20'h00000, 1'b0,20'h00000, 1'b0,20'h00000, 1'b1,1'b0,5'd0,  1'b0,1'b0,1'b0,1'b0},
    '{1'b1,20'h00000, 1'b0,20'h00000, 1'b1,20'hF0010, 1'b0,1'b0,5'd0,  1'b1,1'b0,1'b1,1'b1},
    '{1'b1,20'h00002, 1'b1,20'hF0020, 1'b1,20'h00050, 1'b1,1'b1,5'd20, 1'b1,1'b0,1'b1,1'b1},
    '{1'b1,20'h00004, 1'b1,20'hF0020, 1'b0,20'h00000, 1'b1,1'b0,5'd1,  1'b0,1'b1,1'b0,1'b0},
    '{1'b1,20'h00004, 1'b1,20'h00100, 1'b0,20'h00000, 1'b0,1'b0,5'd0,  1'b1,1'b0,1'b0,1'b0},
    '{1'b1,20'h00006, 1'b1,20'h00100, 1'b1,20'h00200, 1'b0,1'b0,5'd0,  1'b1,1'b1,1'b1,1'b0},
    '{1'b0,20'h00000, 1'b0,20'h00000, 1'b0,20'h00000, 1'b0,1'b0,5'd0,  1'b0,1'b0,1'b0,1'b0},
    '{1'b1,20'h00010, 1'b1,20'h00054, 1'b1,20'h00058, 1'b1,1'b1,5'd22, 1'b0,1'b0,1'b1,1'b0},
    '{1'b1,20'h00010, 1'b1,20'h00054, 1'b0,20'h00000, 1'b1,1'b0,5'd21, 1'b0,1'b0,1'b0,1'b0},
    '{1'b1,20'h00010, 1'b1,20'h00054, 1'b0,20'h00000, 1'b1,1'b0,5'd4,  1'b0,1'b1,1'b0,1'b0},
    '{1'b1,20'h00010, 1'b0,20'h00000, 1'b0,20'h00000, 1'b0,1'b0,5'd0,  1'b1,1'b0,1'b0,1'b0},
    '{1'b0,20'h00000, 1'b0,20'h00000, 1'b0,20'h00000, 1'b0,1'b0,5'd0,  1'b0,1'b0,1'b0,1'b0}
  };

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  endtask

  initial begin
    #800000;
    ntests++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R5 reset state
    chk("R5 reset if_ready", 32'(if_ready), 0);
    chk("R5 reset dr_ready", 32'(dr_ready), 0);
    chk("R5 reset mem_en", 32'(mem_en), 0);
    chk("R5 reset per_en", 32'(per_en), 0);

    // R6 R7 R10 scripted sequence, one row per cycle
    for (int r = 0; r < 21; r++) begin
      cyc(TAB[r].ie, TAB[r].ia, TAB[r].re, TAB[r].ra, TAB[r].we, TAB[r].wa);
      chk($sformatf("R6 row%0d mem_en", r), 32'(mem_en), 32'(TAB[r].m_en));
      chk($sformatf("R6 row%0d if_ready", r), 32'(if_ready), 32'(TAB[r].i_r));
      chk($sformatf("R6 row%0d dr_ready", r), 32'(dr_ready), 32'(TAB[r].d_r));
      chk($sformatf("R6 row%0d dw_ready", r), 32'(dw_ready), 32'(TAB[r].w_r));
      chk($sformatf("R8 row%0d per_en", r), 32'(per_en), 32'(TAB[r].p_en));
      if (TAB[r].m_en) begin
        chk($sformatf("R1 row%0d mem_we", r), 32'(mem_we), 32'(TAB[r].m_we));
        chk($sformatf("R2 row%0d mem_addr", r), 32'(mem_addr), 32'(TAB[r].m_a));
      end
    end

    // R2 R1 read back a written word
    cyc(0, 0, 1, 20'h00044, 0, 0);
    chk("R2 issue dr_ready", 32'(dr_ready), 0);
    chk("R2 issue mem_addr", 32'(mem_addr), 17);
    cyc(0, 0, 1, 20'h00044, 0, 0);
    chk("R2 resp dr_ready", 32'(dr_ready), 1);
    chk("R1 written data", dr_rdata, 32'hD000_0044);

    // R11 instruction region via data port; R9 unmapped write left word 0 alone
    cyc(0, 0, 1, 20'h00000, 0, 0);
    cyc(0, 0, 1, 20'h00000, 0, 0);
    chk("R9 R11 word0 intact", dr_rdata, 32'hA000_0000);

    // R3 miss then R4 hit with R7 data read in the hit cycle
    cyc(1, 20'h00008, 0, 0, 0, 0);
    chk("R3 miss mem_en", 32'(mem_en), 1);
    chk("R3 miss if_ready", 32'(if_ready), 0);
    cyc(1, 20'h00008, 0, 0, 0, 0);
    chk("R3 resp data", if_rdata, 32'hA000_0002);
    cyc(1, 20'h0000A, 1, 20'h00050, 0, 0);
    chk("R4 hit if_ready", 32'(if_ready), 1);
    chk("R4 hit data", if_rdata, 32'hA000_0002);
    chk("R7 read slot mem_addr", 32'(mem_addr), 20);
    cyc(1, 20'h0000A, 1, 20'h00050, 0, 0);
    chk("R7 read data", dr_rdata, 32'hD000_0050);
    chk("R4 hit no mem", 32'(mem_en), 0);

    // R8 peripheral read and recorded write
    cyc(0, 0, 1, 20'hF0024, 0, 0);
    chk("R8 per_addr", per_addr, 32'h000F_0024);
    chk("R8 per_we", 32'(per_we), 0);
    chk("R8 not memory", 32'(mem_en), 0);
    cyc(0, 0, 1, 20'hF0024, 0, 0);
    chk("R8 per rdata", dr_rdata, 32'hBEEF_0024);
    chk("R8 per write addr", pw_addr, 32'h000F_0010);
    chk("R8 per write data", pw_data, 32'hD00F_0010);

    // R9 unmapped read
    cyc(0, 0, 1, 20'h00100, 0, 0);
    cyc(0, 0, 1, 20'h00100, 0, 0);
    chk("R9 unmapped ready", 32'(dr_ready), 1);
    chk("R9 unmapped data", dr_rdata, 0);

    // R5 second reset invalidates the kept word (last fetched word was 2)
    cyc(0, 0, 0, 0, 0, 0);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    cyc(1, 20'h00008, 0, 0, 0, 0);
    chk("R5 refetch mem_en", 32'(mem_en), 1);
    chk("R5 refetch mem_addr", 32'(mem_addr), 2);
    chk("R5 refetch if_ready", 32'(if_ready), 0);
    cyc(0, 0, 0, 0, 0, 0);

    finish_run();
  end
endmodule